// File: doc/BRIEF.md
# Home Directory Coherence Engine

This block is the coherence engine that sits at the home node of a distributed shared memory machine. Every memory block homed at the node has one directory entry: a state (uncached, shared or exclusive) and a presence vector with one bit per cluster. When a cluster exclusively holds a block, that vector is one-hot and names the owner. Clusters send read-miss and write requests. For each request the engine does one of three things. It replies with data from home memory. It forwards the request to the exclusive owner. Or it multicasts invalidations to the other sharers and later grants ownership once every invalidation has been acknowledged.

Only one forward or invalidation transaction can be outstanding at a time. Any request that would collide with it gets a retry reply. A request that touches another block and can be answered directly still goes ahead. The directory entry is rewritten at the moment a request is accepted. The pending slot therefore exists only to hold off competing traffic until the owner reports it is done or the last acknowledgement arrives. The full directory is about a million entries. The array size is a parameter, and every entry behaves the same way.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every entry is uncached with an empty presence vector, and all output valids are low. A reset asserted in mid-operation takes effect at once.
- R2: A read to an uncached or shared block sends a reply with code 0 (shared data) to the requester on the cycle after the request. The requester is added to the presence vector and the block becomes shared.
- R3: A read to a block held exclusively by another cluster produces no reply. Instead, a forward with write flag 0 goes to the owner and carries the requester's id. The block becomes shared, with both owner and requester present.
- R4: A write to an uncached block sends a reply with code 1 (exclusive data) to the requester. The requester becomes the sole owner.
- R5: A write to a shared block that has sharers other than the requester sends no reply. It issues one invalidation whose mask holds exactly those other sharers, and the requester becomes the exclusive owner. Once all of them have acknowledged, a grant goes to the requester on the cycle after the last acknowledgement.
- R6: A write to a shared block whose only sharer is the requester sends code 1 at once, with no invalidation.
- R7: A write to a block held exclusively by another cluster sends a forward with write flag 1 to the owner. The requester becomes the new sole owner.
- R8: A read or write from the cluster that already owns the block exclusively sends code 1 and leaves the entry unchanged.
- R9: While a transaction is outstanding, some requests get code 2 (retry) and leave the directory unchanged. This applies to any request for the pending block, and to any request that would itself need a forward or an invalidation. A request to another block that can be answered directly is served normally.
- R10: An outstanding forward ends only when the owner signals completion. An acknowledgement from a cluster not in the remaining invalidation set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read miss |
| req_src | input | CW | Requesting cluster |
| req_blk | input | IW | Directory index of the block |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_src | input | CW | Acknowledging cluster |
| own_done | input | 1 | Owner finished a forwarded request |
| rep_valid | output | 1 | Reply pulse |
| rep_code | output | 2 | 0 shared data, 1 exclusive data, 2 retry |
| rep_dst | output | CW | Reply destination cluster |
| rep_blk | output | IW | Reply block index |
| fwd_valid | output | 1 | Forward pulse |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_dst | output | CW | Current owner receiving the forward |
| fwd_req | output | CW | Original requester |
| fwd_blk | output | IW | Forwarded block index |
| inv_valid | output | 1 | Invalidation multicast pulse |
| inv_mask | output | NCL | Clusters to invalidate |
| inv_blk | output | IW | Block being invalidated |
| gnt_valid | output | 1 | Ownership grant pulse after all acknowledgements |
| gnt_dst | output | CW | Grant destination |
| gnt_blk | output | IW | Granted block index |

## Verification
A corrupted state or presence vector does not show up until that block is next touched. When it is touched, the very next cycle shows the wrong reply code, a forward aimed at the wrong owner, or a wrong invalidation mask. The tests therefore revisit each block after changing its state, so that every transition is observed through the next response. A pending slot that is stuck or cleared too early shows up as a missing or spurious retry, or as a grant that arrives early or never. Each of these is checked one cycle after the triggering acknowledgement or completion.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2} dir_st_e;
  typedef enum logic [1:0] {AC_REPLY = 2'd0, AC_FWD = 2'd1, AC_INV = 2'd2} dir_act_e;
  localparam logic [1:0] RC_SHR  = 2'd0;
  localparam logic [1:0] RC_EXC  = 2'd1;
  localparam logic [1:0] RC_NACK = 2'd2;
endpackage

// File: rtl/dirc_store.sv
module dirc_store
  import dirc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int NCL     = 16,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  rd_idx,
  output dir_st_e        rd_st,
  output logic [NCL-1:0] rd_map,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  dir_st_e        wr_st,
  input  logic [NCL-1:0] wr_map
);
  dir_st_e        st_arr  [ENTRIES];
  logic [NCL-1:0] map_arr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    dir_st_e        st_r;
    logic [NCL-1:0] map_r;
    logic           we;
    assign we = wr_en && (wr_idx == IW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_UNC;
        map_r <= '0;
      end else if (we) begin
        st_r  <= wr_st;
        map_r <= wr_map;
      end
    end
    assign st_arr[e]  = st_r;
    assign map_arr[e] = map_r;
  end

  assign rd_st  = st_arr[rd_idx];
  assign rd_map = map_arr[rd_idx];

  // R7: an exclusive entry is only ever written with exactly one owner
  a_r7_excl_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_st == ST_EXC) |-> $countones(wr_map) == 1);
endmodule

// File: rtl/dirc_decide.sv
module dirc_decide
  import dirc_pkg::*;
#(
  parameter int NCL = 16,
  localparam int CW = $clog2(NCL)
) (
  input  logic           write,
  input  logic [CW-1:0]  src,
  input  dir_st_e        st,
  input  logic [NCL-1:0] map,
  output dir_act_e       act,
  output logic [1:0]     rcode,
  output dir_st_e        new_st,
  output logic [NCL-1:0] new_map,
  output logic [NCL-1:0] inv_mask,
  output logic [CW-1:0]  owner
);
  logic [NCL-1:0] src_bit;
  logic [NCL-1:0] others;

  assign src_bit = NCL'(1) << src;
  assign others  = map & ~src_bit;

  always_comb begin
    owner = '0;
    for (int i = 0; i < NCL; i++) begin
      if (map[i]) owner = i[CW-1:0];
    end
  end

  always_comb begin
    act      = AC_REPLY;
    rcode    = RC_SHR;
    new_st   = st;
    new_map  = map;
    inv_mask = '0;
    case (st)
      ST_SHR: begin
        if (!write) begin
          new_map = map | src_bit;
        end else if (others == '0) begin
          rcode   = RC_EXC;
          new_st  = ST_EXC;
          new_map = src_bit;
        end else begin
          act      = AC_INV;
          inv_mask = others;
          new_st   = ST_EXC;
          new_map  = src_bit;
        end
      end
      ST_EXC: begin
        if (map[src]) begin
          rcode = RC_EXC;
        end else begin
          act = AC_FWD;
          if (write) begin
            new_map = src_bit;
          end else begin
            new_st  = ST_SHR;
            new_map = map | src_bit;
          end
        end
      end
      default: begin
        rcode   = write ? RC_EXC : RC_SHR;
        new_st  = write ? ST_EXC : ST_SHR;
        new_map = src_bit;
      end
    endcase
  end
endmodule

// File: rtl/dirc_ack_track.sv
module dirc_ack_track #(
  parameter int NCL = 16,
  localparam int CW = $clog2(NCL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NCL-1:0] load_mask,
  input  logic           ack_valid,
  input  logic [CW-1:0]  ack_src,
  output logic           done
);
  logic [NCL-1:0] rem_q, rem_d, cleared;

  assign cleared = rem_q & ~(NCL'(1) << ack_src);

  always_comb begin
    rem_d = rem_q;
    done  = 1'b0;
    if (load) begin
      rem_d = load_mask;
    end else if (ack_valid) begin
      rem_d = cleared;
      done  = (rem_q != '0) && (cleared == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R10: without a new load the outstanding set only ever shrinks
  a_r10_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (rem_q & ~$past(rem_q)) == '0);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dirc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int NCL     = 16,
  localparam int IW     = $clog2(ENTRIES),
  localparam int CW     = $clog2(NCL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [CW-1:0]  req_src,
  input  logic [IW-1:0]  req_blk,
  input  logic           ack_valid,
  input  logic [CW-1:0]  ack_src,
  input  logic           own_done,
  output logic           rep_valid,
  output logic [1:0]     rep_code,
  output logic [CW-1:0]  rep_dst,
  output logic [IW-1:0]  rep_blk,
  output logic           fwd_valid,
  output logic           fwd_write,
  output logic [CW-1:0]  fwd_dst,
  output logic [CW-1:0]  fwd_req,
  output logic [IW-1:0]  fwd_blk,
  output logic           inv_valid,
  output logic [NCL-1:0] inv_mask,
  output logic [IW-1:0]  inv_blk,
  output logic           gnt_valid,
  output logic [CW-1:0]  gnt_dst,
  output logic [IW-1:0]  gnt_blk
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  dir_st_e        cur_st, nxt_st;
  logic [NCL-1:0] cur_map, nxt_map, dec_inv;
  dir_act_e       act;
  logic [1:0]     dec_code;
  logic [CW-1:0]  owner;

  logic          busy_q, busy_d, pinv_q, pinv_d;
  logic [IW-1:0] pblk_q, pblk_d;
  logic [CW-1:0] psrc_q, psrc_d;
  logic          nack, accept, start, inv_done, fwd_end;

  dirc_store #(.ENTRIES(ENTRIES), .NCL(NCL)) u_store (
    .clk(clk), .rst_n(rst_ni), .rd_idx(req_blk), .rd_st(cur_st), .rd_map(cur_map),
    .wr_en(accept), .wr_idx(req_blk), .wr_st(nxt_st), .wr_map(nxt_map));

  dirc_decide #(.NCL(NCL)) u_decide (
    .write(req_write), .src(req_src), .st(cur_st), .map(cur_map), .act(act),
    .rcode(dec_code), .new_st(nxt_st), .new_map(nxt_map), .inv_mask(dec_inv),
    .owner(owner));

  dirc_ack_track #(.NCL(NCL)) u_acks (
    .clk(clk), .rst_n(rst_ni), .load(start && act == AC_INV), .load_mask(dec_inv),
    .ack_valid(ack_valid && busy_q && pinv_q), .ack_src(ack_src), .done(inv_done));

  assign nack    = req_valid && busy_q && ((req_blk == pblk_q) || (act != AC_REPLY));
  assign accept  = req_valid && !nack;
  assign start   = accept && (act != AC_REPLY);
  assign fwd_end = busy_q && !pinv_q && own_done;

  // next state of the pending slot
  always_comb begin
    busy_d = busy_q;
    pinv_d = pinv_q;
    pblk_d = pblk_q;
    psrc_d = psrc_q;
    if (start) begin
      busy_d = 1'b1;
      pinv_d = (act == AC_INV);
      pblk_d = req_blk;
      psrc_d = req_src;
    end else if (inv_done || fwd_end) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pinv_q <= 1'b0;
      pblk_q <= '0;
      psrc_q <= '0;
    end else begin
      busy_q <= busy_d;
      pinv_q <= pinv_d;
      pblk_q <= pblk_d;
      psrc_q <= psrc_d;
    end
  end

  // output strobes
  logic rep_v_d, fwd_v_d, inv_v_d;
  assign rep_v_d = nack || (accept && act == AC_REPLY);
  assign fwd_v_d = start && act == AC_FWD;
  assign inv_v_d = start && act == AC_INV;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_valid <= 1'b0;
      fwd_valid <= 1'b0;
      inv_valid <= 1'b0;
      gnt_valid <= 1'b0;
    end else begin
      rep_valid <= rep_v_d;
      fwd_valid <= fwd_v_d;
      inv_valid <= inv_v_d;
      gnt_valid <= inv_done;
    end
  end

  // payloads, loaded only with their strobe
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_code  <= '0;
      rep_dst   <= '0;
      rep_blk   <= '0;
      fwd_write <= 1'b0;
      fwd_dst   <= '0;
      fwd_req   <= '0;
      fwd_blk   <= '0;
      inv_mask  <= '0;
      inv_blk   <= '0;
      gnt_dst   <= '0;
      gnt_blk   <= '0;
    end else begin
      if (rep_v_d) begin
        rep_code <= nack ? RC_NACK : dec_code;
        rep_dst  <= req_src;
        rep_blk  <= req_blk;
      end
      if (fwd_v_d) begin
        fwd_write <= req_write;
        fwd_dst   <= owner;
        fwd_req   <= req_src;
        fwd_blk   <= req_blk;
      end
      if (inv_v_d) begin
        inv_mask <= dec_inv;
        inv_blk  <= req_blk;
      end
      if (inv_done) begin
        gnt_dst <= psrc_q;
        gnt_blk <= pblk_q;
      end
    end
  end

  // R5: invalidations never target the requester and are never empty
  a_r5_inv_skips_requester: assert property (@(posedge clk) disable iff (!rst_ni)
    inv_valid |-> (inv_mask != '0) && !inv_mask[psrc_q]);
  // R5: a grant follows an acknowledgement in the previous cycle
  a_r5_gnt_after_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    gnt_valid |-> $past(ack_valid));
  // R3: a forward never goes back to the requester
  a_r3_fwd_not_self: assert property (@(posedge clk) disable iff (!rst_ni)
    fwd_valid |-> fwd_dst != fwd_req);
  // R9: retries only while a transaction was outstanding
  a_r9_nack_when_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (rep_valid && rep_code == RC_NACK) |-> $past(busy_q));
  // R8: one request yields exactly one kind of action
  a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({fwd_valid, inv_valid, rep_valid && rep_code != RC_NACK}));
endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
  localparam int ENTRIES = 64;
  localparam int NCL     = 16;
  localparam int IW      = $clog2(ENTRIES);
  localparam int CW      = $clog2(NCL);
  localparam int NV      = 12;

  logic clk, rst_n;
  logic req_valid, req_write, ack_valid, own_done;
  logic [CW-1:0] req_src, ack_src;
  logic [IW-1:0] req_blk;
  logic rep_valid, fwd_valid, fwd_write, inv_valid, gnt_valid;
  logic [1:0] rep_code;
  logic [CW-1:0] rep_dst, fwd_dst, fwd_req, gnt_dst;
  logic [IW-1:0] rep_blk, fwd_blk, inv_blk, gnt_blk;
  logic [NCL-1:0] inv_mask;

  int n_chk = 0;
  int n_fail = 0;

  dir_home_ctrl #(.ENTRIES(ENTRIES), .NCL(NCL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_src(req_src), .req_blk(req_blk), .ack_valid(ack_valid), .ack_src(ack_src),
    .own_done(own_done), .rep_valid(rep_valid), .rep_code(rep_code), .rep_dst(rep_dst),
    .rep_blk(rep_blk), .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_dst(fwd_dst),
    .fwd_req(fwd_req), .fwd_blk(fwd_blk), .inv_valid(inv_valid), .inv_mask(inv_mask),
    .inv_blk(inv_blk), .gnt_valid(gnt_valid), .gnt_dst(gnt_dst), .gnt_blk(gnt_blk));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // kinds: 0 shared data, 1 exclusive data, 2 retry, 3 read forward,
  //        4 write forward, 5 invalidation, 6 nothing, 7 grant
  // vector: {write, src, blk, kind, dst, aux}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 4'd2, 6'd1, 3'd0, 4'd2, 16'd0},  // R1 R2 fresh block read
    {1'b0, 4'd5, 6'd1, 3'd0, 4'd5, 16'd0},  // R2 read of shared block
    {1'b1, 4'd3, 6'd2, 3'd1, 4'd3, 16'd0},  // R4 write to uncached
    {1'b1, 4'd3, 6'd2, 3'd1, 4'd3, 16'd0},  // R8 owner writes again
    {1'b0, 4'd3, 6'd2, 3'd1, 4'd3, 16'd0},  // R8 owner reads
    {1'b0, 4'd7, 6'd3, 3'd0, 4'd7, 16'd0},  // R2
    {1'b1, 4'd7, 6'd3, 3'd1, 4'd7, 16'd0},  // R6 sole sharer upgrades
    {1'b0, 4'd4, 6'd2, 3'd3, 4'd3, 16'd4},  // R3 forward read to owner 3
    {1'b0, 4'd6, 6'd2, 3'd0, 4'd6, 16'd0},  // R3 block now shared
    {1'b1, 4'd9, 6'd3, 3'd4, 4'd7, 16'd9},  // R7 forward write to owner 7
    {1'b1, 4'd1, 6'd3, 3'd4, 4'd9, 16'd1},  // R7 cluster 9 became owner
    {1'b0, 4'd8, 6'd1, 3'd0, 4'd8, 16'd0}   // R2
  };

  task automatic check(input int kind, input logic [CW-1:0] dst, input logic [15:0] aux,
                       input logic [IW-1:0] blk, input string tag);
    logic [63:0] a, e;
    a = '0; e = '0;
    case (kind)
      0, 1, 2: begin
        a = {rep_valid, rep_code, rep_dst, rep_blk, fwd_valid, inv_valid, gnt_valid};
        e = {1'b1, 2'(kind), dst, blk, 1'b0, 1'b0, 1'b0};
      end
      3, 4: begin
        a = {fwd_valid, fwd_write, fwd_dst, fwd_req, fwd_blk, rep_valid, inv_valid};
        e = {1'b1, kind == 4, dst, aux[CW-1:0], blk, 1'b0, 1'b0};
      end
      5: begin
        a = {inv_valid, inv_mask, inv_blk, rep_valid, fwd_valid};
        e = {1'b1, aux, blk, 1'b0, 1'b0};
      end
      7: begin
        a = {gnt_valid, gnt_dst, gnt_blk, rep_valid};
        e = {1'b1, dst, blk, 1'b0};
      end
      default: begin
        a = {rep_valid, fwd_valid, inv_valid, gnt_valid};
        e = '0;
      end
    endcase
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic send(input logic w, input logic [CW-1:0] s, input logic [IW-1:0] b);
    @(negedge clk);
    req_write = w; req_src = s; req_blk = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack(input logic [CW-1:0] s);
    @(negedge clk);
    ack_src = s; ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    own_done = 1'b1;
    @(negedge clk);
    own_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_src = '0; req_blk = '0;
    ack_valid = 1'b0; ack_src = '0; own_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(6, '0, '0, '0, "R1 outputs quiet after reset");

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      send(v[33], v[32:29], v[28:23]);
      check(int'(v[22:20]), v[19:16], v[15:0], v[28:23], $sformatf("vector %0d", i));
      if (v[22:20] == 3'd3 || v[22:20] == 3'd4) done_pulse();
    end

    // R5: block 1 shared by {2,5,8}; cluster 2 writes
    send(1'b1, 4'd2, 6'd1);
    check(5, '0, 16'h0120, 6'd1, "R5 invalidation mask");
    // R9: same block retried, other direct block served, other slow block retried
    send(1'b0, 4'd0, 6'd1);
    check(2, 4'd0, '0, 6'd1, "R9 retry on pending block");
    send(1'b0, 4'd0, 6'd4);
    check(0, 4'd0, '0, 6'd4, "R9 other block served");
    send(1'b1, 4'd0, 6'd2);
    check(2, 4'd0, '0, 6'd2, "R9 retry when slot needed");
    // R10: stray acknowledgement ignored
    ack(4'd11);
    check(6, '0, '0, '0, "R10 stray ack ignored");
    ack(4'd5);
    check(6, '0, '0, '0, "R5 no grant before last ack");
    ack(4'd8);
    check(7, 4'd2, '0, 6'd1, "R5 grant after last ack");
    send(1'b1, 4'd2, 6'd1);
    check(1, 4'd2, '0, 6'd1, "R5 requester now owner");
    // R9: retried write left block 2 shared; a read still gets shared data
    send(1'b0, 4'd0, 6'd2);
    check(0, 4'd0, '0, 6'd2, "R9 retry left entry unchanged");

    // R10: forward stays pending until owner completion
    send(1'b0, 4'd0, 6'd3);
    check(3, 4'd1, 16'd0, 6'd3, "R10 forward to owner 1");
    send(1'b0, 4'd4, 6'd3);
    check(2, 4'd4, '0, 6'd3, "R10 retry before completion");
    done_pulse();
    check(6, '0, '0, '0, "R10 completion is silent");
    send(1'b0, 4'd4, 6'd3);
    check(0, 4'd4, '0, 6'd3, "R10 served after completion");

    // R1: reset in mid-operation
    @(negedge clk);
    req_write = 1'b1; req_src = 4'd0; req_blk = 6'd5; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(6, '0, '0, '0, "R1 asynchronous clear");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(1'b1, 4'd0, 6'd2);
    check(1, 4'd0, '0, 6'd2, "R1 entry uncached after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule